// File: doc/BRIEF.md
# Locality-Driven Way Allocation Controller

This block decides how many ways of a shared set-associative last-level cache one active thread may use. While an epoch runs, the block counts the thread's cache hits by the replacement-stack position at which each hit landed. Position 0 is the most recently used line and position `POS_N-1` is the least recently used one. When the epoch closes, the block compares the count at the front of the stack with the count at the back. A thread whose hits crowd the front is given one more way. A thread whose hits reach deep into the stack, relative to its front hits, gives one up.

The ratio is never divided out. Both thresholds are unsigned fixed-point numbers with `THR_FRAC` fractional bits, and each test is done as a cross-multiplication. Alongside the allocation, the block keeps a capacity-requirement figure. Over a profiling window of `2^win_shift` epochs it averages the way count that was in force during each epoch, then publishes the result with a one-cycle valid strobe. The cache arrays and the replacement logic sit elsewhere. This block only sees hit events tagged with their position and a strobe that marks the end of each epoch.

Top module: `wayalloc_ctrl`

## Requirements
- R1: One hit counter is kept per stack position. A `hit_valid` cycle adds one to the counter that `hit_pos` selects. Only the counters for position 0 (C_first) and position `POS_N-1` (C_last) steer a decision, so hits at middle positions do not move the allocation.
- R2: At an `epoch_end` edge, the way count rises by one if C_first·2^THR_FRAC > `thr_hi`·C_last. The new count is visible from that edge onward.
- R3: At an `epoch_end` edge, the way count falls by one if C_first·2^THR_FRAC < `thr_lo`·C_last.
- R4: The allocation holds when neither test is true, when both tests are true at once (as with inverted thresholds), and when a test is met only with equality.
- R5: The way count stays between `MIN_WAYS` and `MAX_WAYS`, inclusive (1 and 32 by default). A grow at the ceiling and a shrink at the floor both leave it unchanged.
- R6: The way count changes only at an `epoch_end` edge, and it moves by at most one way at a time.
- R7: All position counters clear at every `epoch_end` edge, so each decision sees only the hits of its own epoch.
- R8: A position counter stops at its all-ones value instead of wrapping.
- R9: A window spans 2^`win_shift` epochs. In the cycle after the window's last `epoch_end` edge, `cap_valid` is high for exactly one cycle. At that point `cap_req` equals the sum, over the window's epochs, of the way count in force during each epoch, shifted right by `win_shift` (the fraction is dropped). `cap_req` holds that value until the next window closes.
- R10: While `rst` is high, the way count goes to `INIT_WAYS`, `cap_req` and `cap_valid` go to 0, and all counters and the window clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | A hit occurred this cycle |
| hit_pos | input | POS_W | Stack position of the hit (0 = most recently used) |
| epoch_end | input | 1 | Closes the current epoch |
| thr_lo | input | THR_W | Shrink threshold, THR_FRAC fractional bits |
| thr_hi | input | THR_W | Grow threshold, THR_FRAC fractional bits |
| win_shift | input | SH_W | log2 of the profiling window length in epochs |
| ways | output | WAY_W | Current way allocation |
| cap_req | output | WAY_W | Averaged capacity requirement of the last window |
| cap_valid | output | 1 | One-cycle strobe when cap_req is updated |

## Verification
The checker watches several properties on every cycle. It checks that the allocation stays within its floor and ceiling, that it stays still in any cycle without an epoch strobe, and that it never jumps by more than one way. It also checks that the capacity strobe appears only right after an epoch strobe and always carries an in-range value. Other behaviour can only be shown by the bench's scenarios, because the checker cannot see which direction is correct. These include the grow, shrink and hold choices against the cross-multiplied thresholds, including the equality and inverted-threshold cases. The same holds for ignoring middle-position hits, clearing the counters between epochs, saturation, and the exact window average.

// File: rtl/wayalloc_pkg.sv
package wayalloc_pkg;

    localparam int unsigned DEF_POS_N     = 32;
    localparam int unsigned DEF_CNT_W     = 16;
    localparam int unsigned DEF_THR_W     = 12;
    localparam int unsigned DEF_THR_FRAC  = 4;
    localparam int unsigned DEF_MIN_WAYS  = 1;
    localparam int unsigned DEF_MAX_WAYS  = 32;
    localparam int unsigned DEF_INIT_WAYS = 8;
    localparam int unsigned DEF_MAX_SHIFT = 7;

    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_GROW   = 2'd1,
        STEP_SHRINK = 2'd2
    } step_e;

    // Outcome of the two threshold comparisons
    typedef struct packed {
        logic above;   // front/back ratio beyond upper threshold
        logic below;   // front/back ratio beneath lower threshold
    } cmp_t;

    // Conflicting or absent votes hold; limits suppress the step
    function automatic step_e pick_step(input cmp_t c, input logic at_max, input logic at_min);
        if (c.above && !c.below && !at_max) return STEP_GROW;
        if (c.below && !c.above && !at_min) return STEP_SHRINK;
        return STEP_HOLD;
    endfunction

endpackage

// File: rtl/wayalloc_hist.sv
module wayalloc_hist #(
    parameter int unsigned POS_N = wayalloc_pkg::DEF_POS_N,
    parameter int unsigned CNT_W = wayalloc_pkg::DEF_CNT_W,
    localparam int unsigned POS_W = (POS_N > 1) ? $clog2(POS_N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_valid,
    input  logic [POS_W-1:0] hit_pos,
    input  logic             epoch_end,
    output logic [CNT_W-1:0] c_first,
    output logic [CNT_W-1:0] c_last
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt [POS_N];

    for (genvar g = 0; g < POS_N; g++) begin : g_pos
        logic sel;
        assign sel = hit_valid && (hit_pos == POS_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (epoch_end) begin
                // a hit in the closing cycle opens the next epoch's count
                cnt[g] <= sel ? CNT_W'(1) : '0;
            end else if (sel && (cnt[g] != CNT_MAX)) begin
                cnt[g] <= cnt[g] + CNT_W'(1);
            end
        end
    end

    assign c_first = cnt[0];
    assign c_last  = cnt[POS_N-1];

endmodule

// File: rtl/wayalloc_decide.sv
module wayalloc_decide
    import wayalloc_pkg::*;
#(
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter int unsigned THR_W    = DEF_THR_W,
    parameter int unsigned THR_FRAC = DEF_THR_FRAC,
    parameter int unsigned MIN_WAYS = DEF_MIN_WAYS,
    parameter int unsigned MAX_WAYS = DEF_MAX_WAYS,
    localparam int unsigned WAY_W  = $clog2(MAX_WAYS + 1),
    localparam int unsigned PROD_W = CNT_W + THR_W + 1
) (
    input  logic [CNT_W-1:0] c_first,
    input  logic [CNT_W-1:0] c_last,
    input  logic [THR_W-1:0] thr_lo,
    input  logic [THR_W-1:0] thr_hi,
    input  logic [WAY_W-1:0] ways,
    output step_e            step
);

    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs_hi;
    logic [PROD_W-1:0] rhs_lo;
    cmp_t              cmp;
    logic              at_max;
    logic              at_min;

    // C_first / C_last vs thr / 2^FRAC, cross-multiplied: no divider
    assign lhs    = PROD_W'(c_first) << THR_FRAC;
    assign rhs_hi = PROD_W'(thr_hi) * PROD_W'(c_last);
    assign rhs_lo = PROD_W'(thr_lo) * PROD_W'(c_last);

    assign cmp.above = lhs > rhs_hi;
    assign cmp.below = lhs < rhs_lo;

    assign at_max = ways >= WAY_W'(MAX_WAYS);
    assign at_min = ways <= WAY_W'(MIN_WAYS);

    assign step = pick_step(cmp, at_max, at_min);

endmodule

// File: rtl/wayalloc_capacc.sv
module wayalloc_capacc #(
    parameter int unsigned WAY_W     = 6,
    parameter int unsigned MAX_SHIFT = wayalloc_pkg::DEF_MAX_SHIFT,
    localparam int unsigned SH_W  = $clog2(MAX_SHIFT + 1),
    localparam int unsigned EC_W  = MAX_SHIFT + 1,
    localparam int unsigned SUM_W = WAY_W + MAX_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             epoch_end,
    input  logic [WAY_W-1:0] ways_in,
    input  logic [SH_W-1:0]  win_shift,
    output logic [WAY_W-1:0] cap_req,
    output logic             cap_valid
);

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_next;
    logic [EC_W-1:0]  ep_q;
    logic [SH_W-1:0]  sh_eff;
    logic             last_ep;

    assign sh_eff   = (win_shift > SH_W'(MAX_SHIFT)) ? SH_W'(MAX_SHIFT) : win_shift;
    assign last_ep  = ep_q == ((EC_W'(1) << sh_eff) - EC_W'(1));
    assign sum_next = sum_q + SUM_W'(ways_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q     <= '0;
            ep_q      <= '0;
            cap_req   <= '0;
            cap_valid <= 1'b0;
        end else begin
            cap_valid <= 1'b0;
            if (epoch_end) begin
                if (last_ep) begin
                    cap_req   <= WAY_W'(sum_next >> sh_eff);
                    cap_valid <= 1'b1;
                    sum_q     <= '0;
                    ep_q      <= '0;
                end else begin
                    sum_q <= sum_next;
                    ep_q  <= ep_q + EC_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/wayalloc_ctrl.sv
module wayalloc_ctrl
    import wayalloc_pkg::*;
#(
    parameter int unsigned POS_N     = DEF_POS_N,
    parameter int unsigned CNT_W     = DEF_CNT_W,
    parameter int unsigned THR_W     = DEF_THR_W,
    parameter int unsigned THR_FRAC  = DEF_THR_FRAC,
    parameter int unsigned MIN_WAYS  = DEF_MIN_WAYS,
    parameter int unsigned MAX_WAYS  = DEF_MAX_WAYS,
    parameter int unsigned INIT_WAYS = DEF_INIT_WAYS,
    parameter int unsigned MAX_SHIFT = DEF_MAX_SHIFT,
    localparam int unsigned POS_W = (POS_N > 1) ? $clog2(POS_N) : 1,
    localparam int unsigned WAY_W = $clog2(MAX_WAYS + 1),
    localparam int unsigned SH_W  = $clog2(MAX_SHIFT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_valid,
    input  logic [POS_W-1:0] hit_pos,
    input  logic             epoch_end,
    input  logic [THR_W-1:0] thr_lo,
    input  logic [THR_W-1:0] thr_hi,
    input  logic [SH_W-1:0]  win_shift,
    output logic [WAY_W-1:0] ways,
    output logic [WAY_W-1:0] cap_req,
    output logic             cap_valid
);

    logic [CNT_W-1:0] c_first;
    logic [CNT_W-1:0] c_last;
    step_e            step;
    logic [WAY_W-1:0] ways_q;

    wayalloc_hist #(.POS_N(POS_N), .CNT_W(CNT_W)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .hit_valid (hit_valid),
        .hit_pos   (hit_pos),
        .epoch_end (epoch_end),
        .c_first   (c_first),
        .c_last    (c_last)
    );

    wayalloc_decide #(
        .CNT_W(CNT_W), .THR_W(THR_W), .THR_FRAC(THR_FRAC),
        .MIN_WAYS(MIN_WAYS), .MAX_WAYS(MAX_WAYS)
    ) u_decide (
        .c_first (c_first),
        .c_last  (c_last),
        .thr_lo  (thr_lo),
        .thr_hi  (thr_hi),
        .ways    (ways_q),
        .step    (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ways_q <= WAY_W'(INIT_WAYS);
        end else if (epoch_end) begin
            case (step)
                STEP_GROW:   ways_q <= ways_q + WAY_W'(1);
                STEP_SHRINK: ways_q <= ways_q - WAY_W'(1);
                default:     ways_q <= ways_q;
            endcase
        end
    end

    // the allocation in force during the closing epoch feeds the window sum
    wayalloc_capacc #(.WAY_W(WAY_W), .MAX_SHIFT(MAX_SHIFT)) u_capacc (
        .clk       (clk),
        .rst       (rst),
        .epoch_end (epoch_end),
        .ways_in   (ways_q),
        .win_shift (win_shift),
        .cap_req   (cap_req),
        .cap_valid (cap_valid)
    );

    assign ways = ways_q;

endmodule

// File: rtl/wayalloc_ctrl_chk.sv
module wayalloc_ctrl_chk #(
    parameter int unsigned WAY_W    = 6,
    parameter int unsigned MIN_WAYS = 1,
    parameter int unsigned MAX_WAYS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             epoch_end,
    input logic [WAY_W-1:0] ways,
    input logic [WAY_W-1:0] cap_req,
    input logic             cap_valid
);

    p_bounds_r5: assert property (@(posedge clk) disable iff (rst)
        (ways >= WAY_W'(MIN_WAYS)) && (ways <= WAY_W'(MAX_WAYS)))
        else $error("allocation out of range");

    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !epoch_end |=> $stable(ways))
        else $error("allocation moved without epoch strobe");

    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ways == $past(ways)) ||
                  (ways == $past(ways) + WAY_W'(1)) ||
                  (ways + WAY_W'(1) == $past(ways))))
        else $error("allocation moved by more than one way");

    p_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !epoch_end |=> !cap_valid)
        else $error("capacity strobe without epoch strobe");

    p_cap_range_r9: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> ((cap_req >= WAY_W'(MIN_WAYS)) && (cap_req <= WAY_W'(MAX_WAYS))))
        else $error("capacity figure out of range");

endmodule

bind wayalloc_ctrl wayalloc_ctrl_chk #(
    .WAY_W(WAY_W), .MIN_WAYS(MIN_WAYS), .MAX_WAYS(MAX_WAYS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .epoch_end (epoch_end),
    .ways      (ways),
    .cap_req   (cap_req),
    .cap_valid (cap_valid)
);

// File: tb/wayalloc_ctrl_tb.sv
`timescale 1ns/1ps
module wayalloc_ctrl_tb;

    localparam int POS_N = 32;
    localparam int CNT_W = 6;
    localparam int THR_W = 12;
    localparam int MAXW  = 6;
    localparam int MINW  = 1;
    localparam int INITW = 4;
    localparam int POS_W = 5;
    localparam int WAY_W = 3;
    localparam int SH_W  = 3;

    // columns: front hits, back hits, thr_lo, thr_hi, expected ways (thresholds x16)
    localparam int NV = 10;
    localparam int VEC [NV][5] = '{
        '{10,  2,  8, 32, 5},
        '{10,  2,  8, 32, 6},
        '{10,  2,  8, 32, 6},
        '{ 2, 10,  8, 32, 5},
        '{ 5,  5,  8, 32, 5},
        '{ 0,  0,  8, 32, 5},
        '{ 3,  0,  8, 32, 6},
        '{ 1,  4,  8, 32, 5},
        '{ 4,  2,  8, 32, 5},
        '{ 1,  2,  8, 32, 5}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             hit_valid = 1'b0;
    logic [POS_W-1:0] hit_pos = '0;
    logic             epoch_end = 1'b0;
    logic [THR_W-1:0] thr_lo = 12'd8;
    logic [THR_W-1:0] thr_hi = 12'd32;
    logic [SH_W-1:0]  win_shift = '0;
    logic [WAY_W-1:0] ways;
    logic [WAY_W-1:0] cap_req;
    logic             cap_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wayalloc_ctrl #(
        .POS_N(POS_N), .CNT_W(CNT_W), .THR_W(THR_W), .THR_FRAC(4),
        .MIN_WAYS(MINW), .MAX_WAYS(MAXW), .INIT_WAYS(INITW), .MAX_SHIFT(7)
    ) u_dut (
        .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_pos(hit_pos),
        .epoch_end(epoch_end), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .win_shift(win_shift), .ways(ways), .cap_req(cap_req), .cap_valid(cap_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // hits at front, middle and back positions, then one epoch strobe;
    // returns sampled just after the strobe edge
    task automatic run_epoch(input int n1, input int nm, input int nb);
        for (int k = 0; k < n1; k++) begin
            @(negedge clk); hit_valid = 1'b1; hit_pos = POS_W'(0);
        end
        for (int k = 0; k < nm; k++) begin
            @(negedge clk); hit_valid = 1'b1; hit_pos = POS_W'(POS_N / 2);
        end
        for (int k = 0; k < nb; k++) begin
            @(negedge clk); hit_valid = 1'b1; hit_pos = POS_W'(POS_N - 1);
        end
        @(negedge clk); hit_valid = 1'b0; epoch_end = 1'b1;
        @(negedge clk); epoch_end = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int prev;
        do_reset();
        // R10 reset state
        check("R10 ways", int'(ways), INITW);
        check("R10 cap_req", int'(cap_req), 0);
        check("R10 cap_valid", int'(cap_valid), 0);

        // table walk, window of one epoch: cap_req mirrors the prior allocation
        prev = INITW;
        for (int i = 0; i < NV; i++) begin
            thr_lo = THR_W'(VEC[i][2]);
            thr_hi = THR_W'(VEC[i][3]);
            run_epoch(VEC[i][0], 0, VEC[i][1]);
            if (VEC[i][4] > prev)      check("R2 grow",  int'(ways), VEC[i][4]);
            else if (VEC[i][4] < prev) check("R3 shrink", int'(ways), VEC[i][4]);
            else if (prev == MAXW)     check("R5 ceiling", int'(ways), VEC[i][4]);
            else                       check("R4 hold", int'(ways), VEC[i][4]);
            check("R9 single-epoch valid", int'(cap_valid), 1);
            check("R9 single-epoch value", int'(cap_req), prev);
            prev = VEC[i][4];
        end

        // R1: middle-position hits alone do not steer the allocation
        run_epoch(0, 20, 0);
        check("R1 middle ignored", int'(ways), 5);

        // R7: counters clear between epochs
        run_epoch(2, 0, 10);
        check("R3 shrink before clear", int'(ways), 4);
        run_epoch(0, 0, 0);
        check("R7 cleared", int'(ways), 4);

        // R5 floor
        run_epoch(0, 0, 3); check("R3 step", int'(ways), 3);
        run_epoch(0, 0, 3); check("R3 step", int'(ways), 2);
        run_epoch(0, 0, 3); check("R3 step", int'(ways), 1);
        run_epoch(0, 0, 3); check("R5 floor", int'(ways), 1);

        // R4: both tests true with inverted thresholds
        run_epoch(10, 0, 2); run_epoch(10, 0, 2);
        check("R2 regrow", int'(ways), 3);
        thr_lo = 12'd48; thr_hi = 12'd16;
        run_epoch(2, 0, 1);
        check("R4 conflicting votes", int'(ways), 3);

        // R8: 100 and 70 hits both stop at 63, ratio 1.0 is not above 1.0
        thr_lo = 12'd8; thr_hi = 12'd16;
        run_epoch(100, 0, 70);
        check("R8 saturation", int'(ways), 3);

        // R9: window of four epochs
        win_shift = 3'd2; thr_lo = 12'd8; thr_hi = 12'd32;
        do_reset();
        check("R10 ways again", int'(ways), INITW);
        run_epoch(10, 0, 2); check("R9 open", int'(cap_valid), 0);
        run_epoch(10, 0, 2); check("R9 open", int'(cap_valid), 0);
        run_epoch(10, 0, 2); check("R9 open", int'(cap_valid), 0);
        run_epoch(10, 0, 2);
        check("R9 close valid", int'(cap_valid), 1);
        check("R9 average 21/4", int'(cap_req), 5);
        @(negedge clk);
        check("R9 one-cycle strobe", int'(cap_valid), 0);
        check("R9 value held", int'(cap_req), 5);
        for (int k = 0; k < 4; k++) run_epoch(0, 0, 0);
        check("R9 second valid", int'(cap_valid), 1);
        check("R9 average 24/4", int'(cap_req), 6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule